// File: doc/BRIEF.md
# Sequential Masked AND Gadget

This block computes a bitwise AND of two 32-bit secrets that are each held as a Boolean sharing of `NSHARE` words. The secret value is the XOR of its shares. The result is a new sharing of the same size. Its shares XOR to the AND of the two secrets. All operations are 32 bits wide, so one call evaluates 32 independent masked AND gates side by side. `NSHARE` is a power of two from 2 to 32.

A call begins with a `start` pulse while the block is idle. On that pulse both operand sharings are captured and each output share is seeded with the AND of the like-indexed operand shares. The block then walks every unordered share pair (i, j) with i < j. For each pair it takes one fresh random word from a valid/ready port. The random word goes straight into output share i. Output share j receives the same word folded with both cross products. Pairs are visited in row-major order, one pair per accepted word. When random words are late, the block stalls. After the last pair, `done` pulses for one cycle and the result stays on `c_shares` until the next call is accepted.

Top module: `shared_and_engine`

## Requirements
- R1: After reset, `busy`, `done` and `rnd_ready` are 0 and `c_shares` is all zeros.
- R2: For every one of the 32 bit lanes, the XOR of the output shares equals (XOR of the a shares) AND (XOR of the b shares) once `done` is seen.
- R3: Share k occupies bits [32k+31:32k]. Each output share k starts as a_k AND b_k. The n-th accepted random word s serves the n-th pair in the order i ascending, then j ascending from i+1. That word updates c_i to c_i XOR s and c_j to c_j XOR s XOR (a_i AND b_j) XOR (a_j AND b_i).
- R4: A call accepts exactly NSHARE(NSHARE-1)/2 random words (6 for NSHARE=4). `rnd_ready` is high exactly while `busy` is high.
- R5: While busy, a cycle with `rnd_valid` low changes neither the shares nor the pair position.
- R6: `done` is high for exactly the one cycle after the final word is accepted. `busy` falls at the same edge. `c_shares` then holds its value until the next accepted start.
- R7: A `start` asserted while `busy` is high is ignored, and the running call completes on its original operands.
- R8: A `start` asserted in the cycle where `done` is high is accepted and begins a new call on the operands present in that cycle.
- R9: Random words offered while idle are not accepted (`rnd_ready` low) and leave `c_shares` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a call; taken only when idle |
| a_shares | input | NSHARE*32 | First operand sharing, share k at bits [32k+31:32k] |
| b_shares | input | NSHARE*32 | Second operand sharing, same layout |
| rnd_valid | input | 1 | Random word available |
| rnd_word | input | 32 | Fresh random word |
| rnd_ready | output | 1 | Block accepts a random word this cycle |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle pulse after the last pair |
| c_shares | output | NSHARE*32 | Result sharing, share k at bits [32k+31:32k] |

## Verification
Two events can fall in the same cycle: a new start and the completion of a call. The bench drives `start` with new operands in the very cycle where `done` is high. It then checks that the second call runs on those new operands and yields their exact shares. In the opposite case, the bench raises `start` with different operands during a stall in mid-call. It then checks that the first call still finishes with the shares its original operands and random words predict.

// File: rtl/sae_pkg.sv
package sae_pkg;

    // number of unordered share pairs, one random word each
    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    // width of a share index; at least one bit
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sae_pair_walker.sv
module sae_pair_walker #(
    parameter int NSHARE = 4,
    localparam int IDX_W = sae_pkg::idx_width(NSHARE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] idx_j,
    output logic             last
);

    typedef struct packed {
        logic [IDX_W-1:0] i;
        logic [IDX_W-1:0] j;
    } pos_t;

    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(NSHARE - 1);
    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(NSHARE - 2);

    pos_t pos_q, pos_d;

    assign idx_i = pos_q.i;
    assign idx_j = pos_q.j;
    assign last  = (pos_q.i == LAST_ROW) && (pos_q.j == TOP_IDX);

    always_comb begin
        pos_d = pos_q;
        if (restart) begin
            pos_d.i = '0;
            pos_d.j = IDX_W'(1);
        end else if (step && !last) begin
            if (pos_q.j == TOP_IDX) begin
                pos_d.i = pos_q.i + IDX_W'(1);
                pos_d.j = pos_q.i + IDX_W'(2);
            end else begin
                pos_d.j = pos_q.j + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q.i <= '0;
            pos_q.j <= IDX_W'(1);
        end else begin
            pos_q <= pos_d;
        end
    end

    // R3: the walk always keeps the row index strictly below the column index
    a_r3_row_below_col: assert property (@(posedge clk) disable iff (!rst_n)
        idx_i < idx_j);

    // R5: without a step or restart the position is held
    a_r5_walk_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !restart |=> $stable(idx_i) && $stable(idx_j));

endmodule

// File: rtl/sae_share_update.sv
module sae_share_update #(
    parameter int NSHARE = 4,
    parameter int WORD   = 32,
    localparam int IDX_W = sae_pkg::idx_width(NSHARE),
    localparam int VEC   = NSHARE * WORD
) (
    input  logic [VEC-1:0]   a_vec,
    input  logic [VEC-1:0]   b_vec,
    input  logic [VEC-1:0]   c_vec,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] idx_j,
    input  logic [WORD-1:0]  rnd,
    output logic [VEC-1:0]   c_next
);

    logic [WORD-1:0] a_i, a_j, b_i, b_j;
    logic [WORD-1:0] folded;

    always_comb begin
        a_i    = a_vec[idx_i*WORD +: WORD];
        a_j    = a_vec[idx_j*WORD +: WORD];
        b_i    = b_vec[idx_i*WORD +: WORD];
        b_j    = b_vec[idx_j*WORD +: WORD];
        folded = (rnd ^ (a_i & b_j)) ^ (a_j & b_i);
    end

    for (genvar k = 0; k < NSHARE; k++) begin : g_share
        logic [WORD-1:0] add_row, add_col;
        assign add_row = (IDX_W'(k) == idx_i) ? rnd    : '0;
        assign add_col = (IDX_W'(k) == idx_j) ? folded : '0;
        assign c_next[k*WORD +: WORD] = c_vec[k*WORD +: WORD] ^ add_row ^ add_col;
    end

endmodule

// File: rtl/shared_and_engine.sv
module shared_and_engine #(
    parameter int NSHARE = 4,
    parameter int WORD   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NSHARE*WORD-1:0] a_shares,
    input  logic [NSHARE*WORD-1:0] b_shares,
    input  logic                   rnd_valid,
    input  logic [WORD-1:0]        rnd_word,
    output logic                   rnd_ready,
    output logic                   busy,
    output logic                   done,
    output logic [NSHARE*WORD-1:0] c_shares
);

    localparam int VEC   = NSHARE * WORD;
    localparam int IDX_W = sae_pkg::idx_width(NSHARE);
    localparam int NPAIR = sae_pkg::pair_count(NSHARE);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [VEC-1:0] a;
        logic [VEC-1:0] b;
        logic [VEC-1:0] c;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic             walk_restart, walk_step, walk_last;
    logic [IDX_W-1:0] pi, pj;
    logic [VEC-1:0]   c_upd;

    sae_pair_walker #(.NSHARE(NSHARE)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (walk_restart),
        .step    (walk_step),
        .idx_i   (pi),
        .idx_j   (pj),
        .last    (walk_last)
    );

    sae_share_update #(.NSHARE(NSHARE), .WORD(WORD)) u_upd (
        .a_vec  (cur_q.a),
        .b_vec  (cur_q.b),
        .c_vec  (cur_q.c),
        .idx_i  (pi),
        .idx_j  (pj),
        .rnd    (rnd_word),
        .c_next (c_upd)
    );

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.done   = 1'b0;
        walk_restart = 1'b0;
        walk_step    = 1'b0;
        if (!cur_q.busy) begin
            if (start) begin
                nxt_d.busy   = 1'b1;
                nxt_d.a      = a_shares;
                nxt_d.b      = b_shares;
                nxt_d.c      = a_shares & b_shares;  // diagonal products
                walk_restart = 1'b1;
            end
        end else if (rnd_valid) begin
            nxt_d.c   = c_upd;
            walk_step = 1'b1;
            if (walk_last) begin
                nxt_d.busy = 1'b0;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rnd_ready = cur_q.busy;
    assign busy      = cur_q.busy;
    assign done      = cur_q.done;
    assign c_shares  = cur_q.c;

    // checker-side count of accepted words within the current call
    logic [15:0] chk_words_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      chk_words_q <= '0;
        else if (!cur_q.busy && start)   chk_words_q <= '0;
        else if (cur_q.busy && rnd_valid) chk_words_q <= chk_words_q + 16'd1;
    end

    // R4: a finished call has taken exactly one word per pair
    a_r4_word_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> chk_words_q == 16'(NPAIR));

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done follows the end of a busy period
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    // R5: stall keeps shares and busy
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rnd_valid |=> busy && $stable(c_shares));

    // R9: idle without start keeps the result
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !busy && $stable(c_shares));

    // R7: a start during a call leaves the captured operands alone
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(cur_q.a) && $stable(cur_q.b));

endmodule

// File: tb/sim_shared_and_engine.sv
module sim_shared_and_engine;

    localparam int N     = 4;
    localparam int W     = 32;
    localparam int V     = N * W;
    localparam int NPAIR = N * (N - 1) / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [V-1:0] a_in = '0, b_in = '0;
    logic         rnd_valid = 1'b0;
    logic [W-1:0] rnd_word = '0;
    logic         rnd_ready, busy, done;
    logic [V-1:0] c_out;

    int errors = 0;
    int checks = 0;
    int acc    = 0;

    always #10 clk = ~clk;  // 50 MHz

    shared_and_engine #(.NSHARE(N), .WORD(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_shares(a_in), .b_shares(b_in),
        .rnd_valid(rnd_valid), .rnd_word(rnd_word),
        .rnd_ready(rnd_ready), .busy(busy), .done(done),
        .c_shares(c_out)
    );

    always @(posedge clk) if (rnd_valid && rnd_ready) acc = acc + 1;

    typedef struct packed {
        logic [V-1:0] a;
        logic [V-1:0] b;
        logic [W-1:0] base;
        logic [3:0]   gap;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{a: {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 32'hDEAD_BEEF},
          b: {32'hCAFE_F00D, 32'h0BAD_C0DE, 32'h5555_AAAA, 32'h1357_9BDF},
          base: 32'hA5A5_0001, gap: 4'd0},
        '{a: {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
          b: {32'h8000_0001, 32'h7FFF_FFFE, 32'h0000_0000, 32'hFFFF_FFFF},
          base: 32'h0000_0000, gap: 4'd1},
        '{a: {32'h3C3C_3C3C, 32'h3C3C_3C3C, 32'hF0F0_0F0F, 32'hF0F0_0F0F},
          b: {32'hFFFF_0000, 32'h0F0F_F0F0, 32'h2468_ACE0, 32'h1111_2222},
          base: 32'h7777_1234, gap: 4'd2},
        '{a: {32'h0000_0001, 32'h8000_0000, 32'hAAAA_5555, 32'h6996_9669},
          b: {32'hFEDC_BA98, 32'h7654_3210, 32'h0123_4567, 32'h89AB_CDEF},
          base: 32'hFFFF_FFFF, gap: 4'd0}
    };

    function automatic logic [W-1:0] rw(input logic [W-1:0] base, input int k);
        return base ^ (32'h9E37_79B9 * W'(k + 1));
    endfunction

    function automatic logic [W-1:0] sh(input logic [V-1:0] v, input int k);
        return v[k*W +: W];
    endfunction

    function automatic logic [W-1:0] fold(input logic [V-1:0] v);
        logic [W-1:0] x = '0;
        for (int k = 0; k < N; k++) x ^= sh(v, k);
        return x;
    endfunction

    // expected shares from R3, independent of the RTL structure
    function automatic logic [V-1:0] model(input logic [V-1:0] a, input logic [V-1:0] b,
                                           input logic [W-1:0] base);
        logic [W-1:0] c [N];
        logic [V-1:0] r;
        int n = 0;
        for (int k = 0; k < N; k++) c[k] = sh(a, k) & sh(b, k);
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++) begin
                logic [W-1:0] s = rw(base, n);
                c[i] ^= s;
                c[j] ^= s ^ (sh(a, i) & sh(b, j)) ^ (sh(a, j) & sh(b, i));
                n++;
            end
        for (int k = 0; k < N; k++) r[k*W +: W] = c[k];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [V-1:0] act,
                       input logic [V-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // caller is at a negedge; start is held for one cycle
    task automatic begin_call(input logic [V-1:0] a, input logic [V-1:0] b);
        start = 1'b1; a_in = a; b_in = b;
        acc = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input logic [W-1:0] base, input int gap);
        for (int k = 0; k < NPAIR; k++) begin
            for (int g = 0; g < gap; g++) begin
                rnd_valid = 1'b0;
                rnd_word  = 32'hBAD0_0000 | W'(g);
                @(negedge clk);
                chk(rnd_ready && busy, "R4 ready while busy", V'(rnd_ready), V'(1));
            end
            rnd_valid = 1'b1;
            rnd_word  = rw(base, k);
            @(negedge clk);
        end
        rnd_valid = 1'b0;
    endtask

    // at the negedge after the final accept
    task automatic finish_check(input logic [V-1:0] a, input logic [V-1:0] b,
                                input logic [W-1:0] base);
        logic [V-1:0] exp = model(a, b, base);
        chk(done && !busy, "R6 done pulse", V'({done, busy}), V'(2'b10));
        chk(c_out == exp, "R3 exact shares", c_out, exp);
        chk(fold(c_out) == (fold(a) & fold(b)), "R2 recombined AND",
            V'(fold(c_out)), V'(fold(a) & fold(b)));
        chk(acc == NPAIR, "R4 word count", V'(acc), V'(NPAIR));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [V-1:0] hold;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !rnd_ready && c_out == '0, "R1 reset state",
            V'({busy, done, rnd_ready}), '0);
        chk(c_out == '0, "R1 reset shares", c_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            begin_call(VECS[v].a, VECS[v].b);
            feed(VECS[v].base, int'(VECS[v].gap));
            finish_check(VECS[v].a, VECS[v].b, VECS[v].base);
            hold = c_out;
            @(negedge clk);
            chk(!done && c_out == hold, "R6 done one cycle, result held",
                V'(done), V'(0));
        end

        // R7: start mid-call with other operands is ignored
        begin_call(VECS[0].a, VECS[0].b);
        rnd_valid = 1'b1; rnd_word = rw(VECS[0].base, 0);
        @(negedge clk);
        rnd_valid = 1'b0;
        start = 1'b1; a_in = ~VECS[0].a; b_in = ~VECS[0].b;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R7 still busy after mid-call start", V'(busy), V'(1));
        for (int k = 1; k < NPAIR; k++) begin
            rnd_valid = 1'b1; rnd_word = rw(VECS[0].base, k);
            @(negedge clk);
        end
        rnd_valid = 1'b0;
        chk(c_out == model(VECS[0].a, VECS[0].b, VECS[0].base), "R7 original operands kept",
            c_out, model(VECS[0].a, VECS[0].b, VECS[0].base));
        chk(done, "R7 call completed", V'(done), V'(1));

        // R8: start in the done cycle begins a new call
        @(negedge clk);
        begin_call(VECS[1].a, VECS[1].b);
        feed(VECS[1].base, 0);
        finish_check(VECS[1].a, VECS[1].b, VECS[1].base);
        begin_call(VECS[2].a, VECS[2].b);  // driven while done is high
        chk(busy, "R8 start in done cycle accepted", V'(busy), V'(1));
        feed(VECS[2].base, 1);
        finish_check(VECS[2].a, VECS[2].b, VECS[2].base);
        chk(c_out == model(VECS[2].a, VECS[2].b, VECS[2].base), "R8 new operands used",
            c_out, model(VECS[2].a, VECS[2].b, VECS[2].base));

        // R9: words while idle are refused and do nothing
        @(negedge clk);
        hold = c_out;
        acc = 0;
        for (int k = 0; k < 3; k++) begin
            rnd_valid = 1'b1; rnd_word = 32'h1357_0000 | W'(k);
            @(negedge clk);
            chk(!rnd_ready && !busy, "R9 not ready when idle", V'(rnd_ready), V'(0));
        end
        rnd_valid = 1'b0;
        chk(c_out == hold, "R9 result unchanged", c_out, hold);
        chk(acc == 0, "R9 no word accepted", V'(acc), V'(0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule